// File: doc/BRIEF.md
# Vector Predication Mask Generator

This block turns a small software-written predication table into per-element controls for a vector operation. Software fills up to sixteen configuration entries through a single write port. Each entry names a destination register, an operand class (integer or floating point), a predicate register, and two options: invert and zero. The block rebuilds these entries combinationally into two reverse lookup maps, one per class. Each map has one slot per architectural register.

A lookup request carries a destination register, a class bit and a vector length. The block finds the matching slot and drives the stored predicate register number onto a combinational read port of an external integer register file. It applies the optional inversion to the returned 64-bit value. One cycle later it presents an active-element mask and a zero-write mask.

Requests and responses use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that is not taken stays on the outputs without change until `rsp_ready` is high. The configuration port has no handshake and is always accepted.

Top module: `vpred_mask_gen`

## Requirements
- R1: After reset every configuration entry is cleared (its use bit is 0), `rsp_valid` is low, `req_ready` is high, and every lookup runs unpredicated.
- R2: When `cfg_we` is high at a clock edge, entry `cfg_idx` is loaded with `cfg_wdata`. The field layout is: bit 13 entry in use, bit 12 zero option, bit 11 invert option, bit 10 class (0 integer, 1 floating point), bits 9..5 destination register, bits 4..0 predicate register.
- R3: A lookup whose slot is not enabled returns `rsp_pred`=0, sets the active mask to ones for every element below vl, and returns an all-zero zero mask.
- R4: A lookup whose slot is enabled drives the slot's predicate register number on `rf_raddr` in the request cycle. Active mask bit i equals bit i of the returned `rf_rdata`, and `rsp_pred` is 1.
- R5: When the slot's invert option is set, the register value is bitwise inverted before any mask is formed.
- R6: When the slot's zero option is set, zero mask bit i is 1 for each element below vl that is inactive. When the option is clear, the zero mask is all zero. The two masks never share a set bit.
- R7: Bits at element positions at or above vl are 0 in both masks. A vl above 64 acts as 64, and a vl of 0 gives empty masks.
- R8: Integer and floating-point slots are separate. An entry affects only lookups of its own class.
- R9: When several in-use entries name the same register and class, the highest-numbered entry decides. An entry whose use bit is 0 names no slot.
- R10: A request accepted at a clock edge gives its response in the next cycle. The response uses the table contents from before any write at that same edge, so a write is visible to requests from the following cycle on.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response outputs hold steady and `req_ready` is low. Otherwise `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Entry number to write |
| cfg_wdata | input | 14 | Entry contents (layout in R2) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_rd | input | 5 | Destination register of the operation |
| req_fp | input | 1 | Operand class, 1 for floating point |
| req_vl | input | 7 | Vector length, 0 to 64 |
| rf_raddr | output | 5 | Predicate register number for the register file |
| rf_rdata | input | 64 | Predicate register value, same cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pred | output | 1 | The operation is predicated |
| rsp_active | output | 64 | Per-element active mask |
| rsp_zero | output | 64 | Per-element zero-write mask |

## Verification
The bench uses the default parameters: sixteen entries, thirty-two register slots per class, and 64-element masks. With these values every table index is reachable, including collisions between the lowest and highest entry numbers. They also let full-width masks be checked, along with vl values on both sides of the mask width. A random phase limits destination registers to a few values, so entries keep overwriting and shadowing one another. During that phase back-pressure switches on and off while requests are in flight.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
  localparam int REG_IDX_W = 5;
  localparam int N_CLASS   = 2;

  // Configuration entry, MSB first: use, zero, invert, class, destination, predicate
  typedef struct packed {
    logic                 en;
    logic                 zero;
    logic                 inv;
    logic                 fp;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src;
  } vp_entry_t;

  localparam int ENTRY_W = $bits(vp_entry_t);

  // Reverse lookup slot, one per register per class
  typedef struct packed {
    logic                 en;
    logic                 zero;
    logic                 inv;
    logic [REG_IDX_W-1:0] src;
  } vp_slot_t;
endpackage

// File: rtl/vpred_cfg_table.sv
module vpred_cfg_table
  import vpred_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  vp_entry_t        wr_data,
  output vp_entry_t        entries [N_ENT]
);
  vp_entry_t store_q [N_ENT];

  always_ff @(posedge clk) begin
    for (int e = 0; e < N_ENT; e++) begin
      if (!rst_n)
        store_q[e] <= '0;
      else if (wr_en && wr_idx == IDX_W'(e))
        store_q[e] <= wr_data;
    end
  end

  assign entries = store_q;
endmodule

// File: rtl/vpred_remap.sv
module vpred_remap
  import vpred_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int N_REG = 32
) (
  input  vp_entry_t entries [N_ENT],
  output vp_slot_t  slots   [N_CLASS][N_REG]
);
  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    for (genvar s = 0; s < N_REG; s++) begin : g_slot
      vp_slot_t pick;
      // ascending scan: a later (higher-numbered) match overrides earlier ones
      always_comb begin
        pick = '0;
        for (int e = 0; e < N_ENT; e++) begin
          if (entries[e].en && entries[e].fp == 1'(c) &&
              entries[e].dst == REG_IDX_W'(s)) begin
            pick.en   = 1'b1;
            pick.zero = entries[e].zero;
            pick.inv  = entries[e].inv;
            pick.src  = entries[e].src;
          end
        end
      end
      assign slots[c][s] = pick;
    end
  end
endmodule

// File: rtl/vpred_mask_unit.sv
module vpred_mask_unit
  import vpred_pkg::*;
#(
  parameter int N_REG = 32,
  parameter int XLEN  = 64,
  parameter int VL_W  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REG_IDX_W-1:0] req_rd,
  input  logic                 req_fp,
  input  logic [VL_W-1:0]      req_vl,
  input  vp_slot_t             slots [N_CLASS][N_REG],
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]      rf_rdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_pred,
  output logic [XLEN-1:0]      rsp_active,
  output logic [XLEN-1:0]      rsp_zero
);
  vp_slot_t        hit;
  logic [XLEN-1:0] len_mask;
  logic [XLEN-1:0] pred_val;
  logic [XLEN-1:0] act_d;
  logic [XLEN-1:0] zero_d;
  logic            take;

  assign hit      = slots[req_fp][req_rd];
  assign rf_raddr = hit.src;

  for (genvar i = 0; i < XLEN; i++) begin : g_len
    assign len_mask[i] = VL_W'(i) < req_vl;
  end

  assign pred_val = hit.inv ? ~rf_rdata : rf_rdata;
  assign act_d    = hit.en ? (pred_val & len_mask) : len_mask;
  assign zero_d   = (hit.en && hit.zero) ? (~pred_val & len_mask) : '0;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_pred   <= 1'b0;
      rsp_active <= '0;
      rsp_zero   <= '0;
    end else begin
      if (take) begin
        rsp_valid  <= 1'b1;
        rsp_pred   <= hit.en;
        rsp_active <= act_d;
        rsp_zero   <= zero_d;
      end else if (rsp_ready) begin
        rsp_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpred_mask_gen.sv
module vpred_mask_gen
  import vpred_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int N_REG = 32,
  parameter int XLEN  = 64,
  localparam int CIDX_W = $clog2(N_ENT),
  localparam int VL_W   = $clog2(XLEN) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CIDX_W-1:0]    cfg_idx,
  input  logic [ENTRY_W-1:0]   cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REG_IDX_W-1:0] req_rd,
  input  logic                 req_fp,
  input  logic [VL_W-1:0]      req_vl,
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]      rf_rdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_pred,
  output logic [XLEN-1:0]      rsp_active,
  output logic [XLEN-1:0]      rsp_zero
);
  vp_entry_t entries [N_ENT];
  vp_slot_t  slots   [N_CLASS][N_REG];

  vpred_cfg_table #(.N_ENT(N_ENT)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (vp_entry_t'(cfg_wdata)),
    .entries (entries)
  );

  vpred_remap #(.N_ENT(N_ENT), .N_REG(N_REG)) u_remap (
    .entries (entries),
    .slots   (slots)
  );

  vpred_mask_unit #(.N_REG(N_REG), .XLEN(XLEN), .VL_W(VL_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_rd     (req_rd),
    .req_fp     (req_fp),
    .req_vl     (req_vl),
    .slots      (slots),
    .rf_raddr   (rf_raddr),
    .rf_rdata   (rf_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_pred   (rsp_pred),
    .rsp_active (rsp_active),
    .rsp_zero   (rsp_zero)
  );
endmodule

// File: rtl/vpred_mask_gen_chk.sv
module vpred_mask_gen_chk #(
  parameter int XLEN = 64,
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VL_W-1:0] req_vl,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_pred,
  input logic [XLEN-1:0] rsp_active,
  input logic [XLEN-1:0] rsp_zero
);
  logic [VL_W-1:0] seen_vl;
  logic [XLEN-1:0] seen_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_vl <= '0;
    else if (req_valid && req_ready) seen_vl <= req_vl;
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_m
    assign seen_mask[i] = VL_W'(i) < seen_vl;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  // R10
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_active) &&
                                   $stable(rsp_zero) && $stable(rsp_pred)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R6
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_active & rsp_zero) == '0));

  // R3
  unpred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pred) |-> (rsp_zero == '0 && rsp_active == seen_mask));

  // R7
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_active | rsp_zero) & ~seen_mask) == '0));
endmodule

bind vpred_mask_gen vpred_mask_gen_chk #(.XLEN(XLEN), .VL_W(VL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vl     (req_vl),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_pred   (rsp_pred),
  .rsp_active (rsp_active),
  .rsp_zero   (rsp_zero)
);

// File: tb/vpred_mask_gen_bench.sv
module vpred_mask_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [13:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_rd = '0;
  logic        req_fp = 1'b0;
  logic [6:0]  req_vl = '0;
  logic [4:0]  rf_raddr;
  logic [63:0] rf_rdata;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_pred;
  logic [63:0] rsp_active;
  logic [63:0] rsp_zero;

  logic [63:0] rf_mem [32];
  assign rf_rdata = rf_mem[rf_raddr];

  always #4 clk = ~clk;

  vpred_mask_gen u_vpred_mask_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_fp(req_fp), .req_vl(req_vl), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pred(rsp_pred), .rsp_active(rsp_active), .rsp_zero(rsp_zero)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [13:0] m_cfg [16];
  logic        m_valid = 1'b0;
  logic        m_pred = 1'b0;
  logic [63:0] m_act = '0;
  logic [63:0] m_zero = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input bit en, input bit zr, input bit inv,
                                     input bit fp, input int dst, input int src);
    return {en, zr, inv, fp, 5'(dst), 5'(src)};
  endfunction

  // scan entries in order; the last in-use match wins
  task automatic model_eval(input logic [4:0] rd, input logic fp, input int vl,
                            output logic p, output logic [63:0] a, output logic [63:0] z);
    logic [63:0] lm;
    logic [63:0] pv;
    int found;
    int lim;
    found = -1;
    for (int e = 0; e < 16; e++)
      if (m_cfg[e][13] && m_cfg[e][10] == fp && m_cfg[e][9:5] == rd) found = e;
    lim = (vl > 64) ? 64 : vl;
    lm = '0;
    for (int i = 0; i < lim; i++) lm[i] = 1'b1;
    if (found < 0) begin
      p = 1'b0; a = lm; z = '0;
    end else begin
      pv = rf_mem[m_cfg[found][4:0]];
      if (m_cfg[found][11]) pv = ~pv;
      p = 1'b1;
      a = pv & lm;
      z = m_cfg[found][12] ? (~pv & lm) : '0;
    end
  endtask

  task automatic step(input string tag);
    logic nv, np, rdy;
    logic [63:0] na, nz;
    #1;
    rdy = !m_valid || rsp_ready;
    check(req_ready == rdy, tag, "req_ready", 64'(req_ready), 64'(rdy));
    if (req_valid && rdy) begin
      model_eval(req_rd, req_fp, int'(req_vl), np, na, nz);
      nv = 1'b1;
    end else begin
      nv = m_valid && !rsp_ready; np = m_pred; na = m_act; nz = m_zero;
    end
    @(posedge clk);
    m_valid = nv; m_pred = np; m_act = na; m_zero = nz;
    if (cfg_we) m_cfg[cfg_idx] = cfg_wdata;
    #1;
    check(rsp_valid == m_valid, tag, "rsp_valid", 64'(rsp_valid), 64'(m_valid));
    if (m_valid) begin
      check(rsp_pred == m_pred, tag, "rsp_pred", 64'(rsp_pred), 64'(m_pred));
      check(rsp_active == m_act, tag, "rsp_active", rsp_active, m_act);
      check(rsp_zero == m_zero, tag, "rsp_zero", rsp_zero, m_zero);
    end
  endtask

  task automatic wr(input int idx, input logic [13:0] d, input string tag);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d; req_valid = 1'b0;
    step(tag);
    cfg_we = 1'b0;
  endtask

  task automatic look(input int rd, input bit fp, input int vl, input string tag);
    req_valid = 1'b1; req_rd = 5'(rd); req_fp = fp; req_vl = 7'(vl);
    step(tag);
    req_valid = 1'b0;
    step(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) rf_mem[r] = {$urandom, $urandom};
    rf_mem[7] = 64'h00FF_0F0F_AAAA_1234;
    rf_mem[9] = 64'hF0F0_0000_FFFF_8001;
    rf_mem[1] = 64'h0000_0000_0000_00F1;
    rf_mem[2] = 64'h8000_0000_0000_0302;
    for (int e = 0; e < 16; e++) m_cfg[e] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1");
    look(3, 0, 64, "R1");
    look(3, 1, 64, "R1");
    look(17, 0, 20, "R3");
    // R2 / R4: entry 0 maps int r3 to predicate r7; looked up the next cycle (R10)
    wr(0, mk(1, 0, 0, 0, 3, 7), "R2");
    look(3, 0, 64, "R4");
    // R5 invert
    wr(0, mk(1, 0, 1, 0, 3, 7), "R5");
    look(3, 0, 64, "R5");
    // R6 zero option with and without invert
    wr(0, mk(1, 1, 0, 0, 3, 7), "R6");
    look(3, 0, 64, "R6");
    wr(0, mk(1, 1, 1, 0, 3, 7), "R6");
    look(3, 0, 40, "R6");
    // R7 lengths
    look(3, 0, 10, "R7");
    look(3, 0, 0, "R7");
    look(3, 0, 100, "R7");
    look(3, 0, 63, "R7");
    // R8 class separation
    look(3, 1, 64, "R8");
    wr(1, mk(1, 0, 0, 1, 3, 9), "R8");
    look(3, 1, 64, "R8");
    look(3, 0, 64, "R8");
    // R9 collisions
    wr(2, mk(1, 0, 0, 0, 5, 1), "R9");
    wr(9, mk(1, 0, 0, 0, 5, 2), "R9");
    look(5, 0, 64, "R9");
    wr(15, mk(1, 0, 1, 1, 5, 1), "R9");
    look(5, 0, 64, "R9");
    wr(9, mk(0, 0, 0, 0, 5, 2), "R9");
    look(5, 0, 64, "R9");
    // R10 write and lookup at the same edge: old contents used
    cfg_we = 1'b1; cfg_idx = 4'd2; cfg_wdata = mk(1, 0, 0, 0, 5, 7);
    req_valid = 1'b1; req_rd = 5'd5; req_fp = 1'b0; req_vl = 7'd64;
    step("R10");
    cfg_we = 1'b0;
    step("R10");
    req_valid = 1'b0;
    step("R10");
    // R11 back-pressure with requests waiting
    req_valid = 1'b1; req_rd = 5'd3; req_vl = 7'd33; rsp_ready = 1'b0;
    step("R11");
    req_rd = 5'd5;
    repeat (3) step("R11");
    rsp_ready = 1'b1;
    step("R11");
    req_valid = 1'b0;
    repeat (2) step("R11");
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      cfg_we    = ($urandom % 6) == 0;
      cfg_idx   = 4'($urandom);
      cfg_wdata = {1'($urandom % 4 != 0), 3'($urandom), 5'($urandom % 3), 5'($urandom)};
      req_valid = ($urandom % 3) != 0;
      req_rd    = 5'($urandom % 3);
      req_fp    = 1'($urandom);
      req_vl    = 7'($urandom % 80);
      rsp_ready = ($urandom % 4) != 0;
      step("R4");
    end
    cfg_we = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    step("R11");
    summary();
    $finish;
  end
endmodule